// File: doc/BRIEF.md
# Mode-Switchable Dual-Channel FIFO

This block is a clock-domain-crossing FIFO whose layout is chosen by one mode input. With the mode low it acts as a single FIFO. Each entry is a 24-bit word made from both 12-bit input ports, and it is written on write clock 0. With the mode high it acts as two independent 12-bit FIFOs. Each of them has its own write clock, write enable, read enable and output enable. All reads happen on one common read clock.

Each channel stores its words in a register array. Its write and read pointers cross clock domains as Gray code through two-flop synchronizers. Full is produced in the write domain and empty in the read domain. A write to a full channel is dropped, and so is a read from an empty channel. Changing the mode returns both channels to empty. The mode must be changed only while no write or read is in progress.

Top module: `mfifo_dual`

## Requirements
- R1: With `dual_sel`=0, a rising edge of `wclk0` while `wen0_n` is low stores the 24-bit word {`d1`,`d0`}, with `d1` in the upper 12 bits.
- R2: With `dual_sel`=0, a rising edge of `clk_rd` while `ren0_n` and `oe0_n` are both low and the FIFO is not empty moves the oldest stored word to {`q1`,`q0`}. Words leave in write order.
- R3: With `dual_sel`=0, `wclk1`, `wen1_n`, `ren1_n` and `oe1_n` have no effect. `empty1` reads 1 and `full1` reads 0.
- R4: With `dual_sel`=1, channel 0 stores `d0` on `wclk0` while `wen0_n` is low, and channel 1 stores `d1` on `wclk1` while `wen1_n` is low. The channels are independent, and bit 11 is the MSB of every port.
- R5: With `dual_sel`=1, channel 0 reads to `q0` using `ren0_n`/`oe0_n`, and channel 1 reads to `q1` using `ren1_n`/`oe1_n`. Both read on `clk_rd` and keep write order.
- R6: A read takes place only when both the read enable and the output enable of that channel are low. Otherwise the output and the read pointer keep their values.
- R7: A channel raises full once it holds DEPTH words. A write to a full channel is dropped and the write pointer does not move.
- R8: A read from an empty channel is dropped. The output holds and the read pointer does not move.
- R9: After reset, and after any change of `dual_sel`, both channels are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Common read clock |
| rst | input | 1 | Synchronous active-high reset, seen by every clock |
| dual_sel | input | 1 | Layout select: 0 one 24-bit channel, 1 two 12-bit channels |
| wclk0 | input | 1 | Write clock of channel 0 (and of the wide FIFO) |
| wen0_n | input | 1 | Active-low write enable, channel 0 |
| d0 | input | 12 | Channel 0 data, or low half of the wide word |
| wclk1 | input | 1 | Write clock of channel 1 (dual layout only) |
| wen1_n | input | 1 | Active-low write enable, channel 1 |
| d1 | input | 12 | Channel 1 data, or high half of the wide word |
| ren0_n | input | 1 | Active-low read enable, channel 0 |
| oe0_n | input | 1 | Active-low output enable, channel 0 |
| ren1_n | input | 1 | Active-low read enable, channel 1 |
| oe1_n | input | 1 | Active-low output enable, channel 1 |
| q0 | output | 12 | Channel 0 output, or low half of the wide word |
| q1 | output | 12 | Channel 1 output, or high half of the wide word |
| empty0 | output | 1 | Channel 0 empty (read domain) |
| full0 | output | 1 | Channel 0 full (write-0 domain) |
| empty1 | output | 1 | Channel 1 empty (read domain) |
| full1 | output | 1 | Channel 1 full (write-1 domain) |

## Verification
On every clock edge the assertions check the following:
- A full channel never moves its write pointer.
- An empty channel, or a channel whose read and output enables are not both low, keeps its output and read pointer.
- Channel 1 reports empty whenever the single layout is selected.
- A mode change leaves channel 0 empty.

Only the bench scenarios can show that data leaves in write order and that the halves of the wide word are placed correctly. The same holds for the independence of the two channels under different write clocks and for the exact depth at which full rises.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  localparam int PORT_W = 12;
  typedef enum logic {LAYOUT_WIDE = 1'b0, LAYOUT_SPLIT = 1'b1} layout_e;
endpackage

// File: rtl/mfifo_gsync.sv
module mfifo_gsync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (clr) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/mfifo_chan.sv
module mfifo_chan #(
  parameter int W  = 12,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         wclr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rclr,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wbin_nx, wgray_nx, rbin_nx, rgray_nx;
  logic [PW-1:0] rgray_w, wgray_r;
  logic          wr_ok, rd_ok;

  assign wr_ok    = push & ~full & ~wclr;
  assign wbin_nx  = wbin + PW'(wr_ok);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;

  always_ff @(posedge wclk) begin
    if (wclr) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
  end

  assign rd_ok    = pop & ~empty & ~rclr;
  assign rbin_nx  = rbin + PW'(rd_ok);
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge rclk) begin
    if (rclr) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
      rdata <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wgray_r);
      if (rd_ok) rdata <= mem[rbin[AW-1:0]];
    end
  end

  mfifo_gsync #(.W(PW)) i_sync_r2w (.clk(wclk), .clr(wclr), .d(rgray), .q(rgray_w));
  mfifo_gsync #(.W(PW)) i_sync_w2r (.clk(rclk), .clr(rclr), .d(wgray), .q(wgray_r));

  // R7: a write presented while full leaves the write pointer where it was
  a_r7_no_overflow: assert property (@(posedge wclk) disable iff (wclr)
    (full && push) |=> (wbin == $past(wbin)));

  // R8: an empty channel neither advances nor changes its output
  a_r8_no_underflow: assert property (@(posedge rclk) disable iff (rclr)
    empty |=> ((rbin == $past(rbin)) && $stable(rdata)));

  // R6: without a read request the output and read pointer hold
  a_r6_hold_idle: assert property (@(posedge rclk) disable iff (rclr)
    !pop |=> ($stable(rdata) && (rbin == $past(rbin))));
endmodule

// File: rtl/mfifo_dual.sv
module mfifo_dual
  import mfifo_pkg::*;
#(
  parameter int CW = PORT_W,
  parameter int AW = 3
) (
  input  logic          clk_rd,
  input  logic          rst,
  input  logic          dual_sel,
  input  logic          wclk0,
  input  logic          wen0_n,
  input  logic [CW-1:0] d0,
  input  logic          wclk1,
  input  logic          wen1_n,
  input  logic [CW-1:0] d1,
  input  logic          ren0_n,
  input  logic          oe0_n,
  input  logic          ren1_n,
  input  logic          oe1_n,
  output logic [CW-1:0] q0,
  output logic [CW-1:0] q1,
  output logic          empty0,
  output logic          full0,
  output logic          empty1,
  output logic          full1
);
  localparam int WW = 2 * CW;

  layout_e       lay, lay_w0_q, lay_rd_q;
  logic          wclr0, rclr0, wclr1, rclr1;
  logic [WW-1:0] wide_wdata, wide_rdata;
  logic [CW-1:0] nar_rdata;

  assign lay = layout_e'(dual_sel);

  always_ff @(posedge wclk0) lay_w0_q <= lay;
  always_ff @(posedge clk_rd) lay_rd_q <= lay;

  // channel 0 clears on reset or on any layout change seen in its domain
  assign wclr0 = rst | (lay != lay_w0_q);
  assign rclr0 = rst | (lay != lay_rd_q);
  // channel 1 is held empty for as long as the wide layout is selected
  assign wclr1 = rst | (lay == LAYOUT_WIDE);
  assign rclr1 = rst | (lay == LAYOUT_WIDE);

  assign wide_wdata = (lay == LAYOUT_SPLIT) ? {{CW{1'b0}}, d0} : {d1, d0};

  mfifo_chan #(.W(WW), .AW(AW)) i_ch0 (
    .wclk(wclk0), .wclr(wclr0), .push(~wen0_n), .wdata(wide_wdata), .full(full0),
    .rclk(clk_rd), .rclr(rclr0), .pop(~ren0_n & ~oe0_n), .rdata(wide_rdata),
    .empty(empty0)
  );

  mfifo_chan #(.W(CW), .AW(AW)) i_ch1 (
    .wclk(wclk1), .wclr(wclr1), .push(~wen1_n), .wdata(d1), .full(full1),
    .rclk(clk_rd), .rclr(rclr1), .pop(~ren1_n & ~oe1_n), .rdata(nar_rdata),
    .empty(empty1)
  );

  assign q0 = wide_rdata[CW-1:0];
  assign q1 = (lay == LAYOUT_SPLIT) ? nar_rdata : wide_rdata[WW-1:CW];

  // R3: channel 1 reports empty while the wide layout is in use
  a_r3_ch1_idle: assert property (@(posedge clk_rd) disable iff (rst)
    !dual_sel |=> empty1);

  // R9: a layout change leaves channel 0 empty on the next read edge
  a_r9_mode_clears: assert property (@(posedge clk_rd) disable iff (rst)
    (dual_sel != $past(dual_sel)) |=> empty0);
endmodule

// File: tb/test_mfifo_dual.sv
module test_mfifo_dual;
  localparam int CW = 12;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk_rd = 0, wclk0 = 0, wclk1 = 0;
  logic rst = 1, dual_sel = 1;
  logic wen0_n = 1, wen1_n = 1, ren0_n = 1, oe0_n = 1, ren1_n = 1, oe1_n = 1;
  logic [CW-1:0] d0 = '0, d1 = '0, q0, q1;
  logic empty0, full0, empty1, full1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_rd = ~clk_rd;
  always #2 wclk0 = ~wclk0;
  always #3 wclk1 = ~wclk1;

  mfifo_dual #(.CW(CW), .AW(AW)) i_mfifo_dual (
    .clk_rd(clk_rd), .rst(rst), .dual_sel(dual_sel),
    .wclk0(wclk0), .wen0_n(wen0_n), .d0(d0),
    .wclk1(wclk1), .wen1_n(wen1_n), .d1(d1),
    .ren0_n(ren0_n), .oe0_n(oe0_n), .ren1_n(ren1_n), .oe1_n(oe1_n),
    .q0(q0), .q1(q1), .empty0(empty0), .full0(full0),
    .empty1(empty1), .full1(full1)
  );

  // bit 12 selects the channel, bits 11:0 are the data
  localparam logic [12:0] VEC [10] = '{
    13'h0_001, 13'h1_800, 13'h0_FFF, 13'h1_123, 13'h0_A5A,
    13'h1_5A5, 13'h0_800, 13'h1_FFF, 13'h1_000, 13'h0_3C3
  };

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr0(logic [CW-1:0] a, logic [CW-1:0] b);
    @(negedge wclk0); wen0_n = 0; d0 = a; d1 = b;
    @(negedge wclk0); wen0_n = 1;
  endtask

  task automatic wr1(logic [CW-1:0] b);
    @(negedge wclk1); wen1_n = 0; d1 = b;
    @(negedge wclk1); wen1_n = 1;
  endtask

  task automatic rd(int ch, bit ren, bit oe);
    @(negedge clk_rd);
    if (ch == 0) begin ren0_n = ren; oe0_n = oe; end
    else begin ren1_n = ren; oe1_n = oe; end
    @(negedge clk_rd);
    ren0_n = 1; oe0_n = 1; ren1_n = 1; oe1_n = 1;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk_rd);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] e0 [DEPTH];
    logic [CW-1:0] e1 [DEPTH];
    int n0, n1;
    logic [23:0] last;
    repeat (6) @(negedge wclk1);
    rst = 0;
    settle();
    check("R9 reset empty0", 24'(empty0), 24'd1);
    check("R9 reset empty1", 24'(empty1), 24'd1);
    check("R7 reset full0", 24'(full0), 24'd0);

    // dual layout: walk the vector table
    n0 = 0; n1 = 0;
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][12]) begin wr1(VEC[i][11:0]); e1[n1] = VEC[i][11:0]; n1++; end
      else begin wr0(VEC[i][11:0], 12'h000); e0[n0] = VEC[i][11:0]; n0++; end
    end
    settle();
    check("R4 ch0 not empty", 24'(empty0), 24'd0);
    check("R4 ch1 not empty", 24'(empty1), 24'd0);
    for (int i = 0; i < n0; i++) begin
      rd(0, 0, 0);
      check("R5 ch0 order", 24'(q0), 24'(e0[i]));
    end
    for (int i = 0; i < n1; i++) begin
      rd(1, 0, 0);
      check("R5 ch1 order", 24'(q1), 24'(e1[i]));
    end
    settle();
    check("R8 ch0 drained", 24'(empty0), 24'd1);
    check("R8 ch1 drained", 24'(empty1), 24'd1);
    rd(1, 0, 0);
    check("R8 read empty holds q1", 24'(q1), 24'(e1[n1-1]));

    // R6: oe or ren high blocks the read
    wr1(12'h6B7); wr1(12'h2C4);
    settle();
    rd(1, 0, 1);
    check("R6 oe high holds q1", 24'(q1), 24'(e1[n1-1]));
    rd(1, 1, 0);
    check("R6 ren high holds q1", 24'(q1), 24'(e1[n1-1]));
    rd(1, 0, 0);
    check("R6 pointer unmoved", 24'(q1), 24'h6B7);

    // R9: layout change empties both channels
    wr0(12'h111, 12'h000);
    settle();
    dual_sel = 0;
    settle();
    check("R9 mode change empty0", 24'(empty0), 24'd1);
    check("R9 mode change empty1", 24'(empty1), 24'd1);

    // single layout, fill past depth
    for (int i = 0; i <= DEPTH; i++) wr0(CW'(12'h100 + i), CW'(12'h800 + i));
    check("R7 full after depth", 24'(full0), 24'd1);
    // R3: channel-1 controls do nothing in wide layout
    wr1(12'hABC);
    rd(1, 0, 0);
    check("R3 empty1 in wide", 24'(empty1), 24'd1);
    check("R3 full1 in wide", 24'(full1), 24'd0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd(0, 0, 0);
      last = {CW'(12'h800 + i), CW'(12'h100 + i)};
      check("R1 R2 wide word", {q1, q0}, last);
    end
    settle();
    check("R7 dropped write not stored", 24'(empty0), 24'd1);
    rd(0, 0, 0);
    check("R8 wide empty read holds", {q1, q0}, last);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule